// File: doc/BRIEF.md
# Receive Data Transfer Engine

This block takes the data words of a received bus message, already decoded and checked upstream, and hands them to a local subsystem over a 16-bit parallel write port. Before each transfer it asks for the local bus by raising a request line and waiting for a grant. It has two transfer modes, chosen at the start of each message.

In word mode, every stored word gets its own request, and a grant leads to one write. In burst mode, the whole message collects in an internal buffer. The block asks for the bus only once, after the message has ended and was judged valid. It then streams every word out on consecutive cycles.

A request that gets no grant within a tick-counted limit drives the active-low failure output. In word mode, the remaining words are still transferred after such a timeout. If a message is valid, carries no mode code, and every word was written, the active-low good-block output pulses low for two cycles.

Stream rules: there is no back-pressure on either stream. The input side has no ready signal, because words arrive at bus pace and cannot be stalled. On the output side, the grant acts as the ready for a whole request. Once granted, the write strobe cannot be held off.

Top module: `rx_word_dma`

## Requirements
- R1: While reset is low and after its release, `dma_req` and `wr_stb` are 0, and `hs_fail_n` and `gbr_n` are 1.
- R2: In word mode (`burst_en`=0 at `msg_start`), each stored word gets its own rising edge of `dma_req`. The cycle after a grant, `wr_stb` is high for one cycle. At the same time `wr_data` holds that word and `wr_addr` holds its 0-based position in the message.
- R3: In burst mode (`burst_en`=1 at `msg_start`), `dma_req` does not rise before `msg_end` has been seen with `msg_ok`=1. It then rises once. After the grant, all words are written on consecutive cycles, at addresses 0 to n-1.
- R4: `dma_req` stays high until a grant or a timeout, and drops in the cycle after the grant.
- R5: A request that sees `HS_LIMIT` cycles with `tick`=1 and no grant drives `hs_fail_n` low. It stays low until the next `msg_start`. Cycles with `tick`=0 do not count, and the count restarts for every request.
- R6: In word mode, a timed-out request discards only its own word. Later words are still requested and written at their own positions.
- R7: In burst mode, a timed-out request discards the whole buffer, and no word is written.
- R8: `gbr_n` goes low for exactly two cycles, once, after the last write of a message. The message must have ended with `msg_ok`=1 and `mode_code`=0, and every one of its words must have been written.
- R9: `gbr_n` stays high for a message that is a mode-code message, is invalid, or lost a word to a timeout.
- R10: In burst mode, a message ending with `msg_ok`=0 raises no request, and its buffered words are dropped.
- R11: `msg_start` empties the buffer and resets the word position and the failure state. After a `msg_start`, words left from an unfinished message are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| burst_en | input | 1 | Mode select, sampled at `msg_start`: 1 = burst, 0 = word |
| msg_start | input | 1 | One-cycle pulse when a new receive command begins |
| word_valid | input | 1 | A decoded data word is present this cycle |
| word_data | input | DATA_W | Decoded data word |
| msg_end | input | 1 | One-cycle pulse after the last word of the message |
| msg_ok | input | 1 | Message validity, sampled with `msg_end` |
| mode_code | input | 1 | Message is a mode-code message, sampled with `msg_end` |
| tick | input | 1 | Timer enable for the grant timeout |
| dma_gnt | input | 1 | Grant from the local bus owner |
| dma_req | output | 1 | Request for the local bus |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | ADDR_W | Word position within the message |
| wr_data | output | DATA_W | Word being written |
| hs_fail_n | output | 1 | Active-low grant-timeout indication |
| gbr_n | output | 1 | Active-low good-block pulse |

## Verification
Several properties are checked on every cycle:
- `dma_req` drops after a grant.
- In word mode, each write follows a grant.
- In burst mode, a request never exists without a valid ended message.
- The good-block pulse has its two-cycle shape, and only qualified messages produce it.
- The failure output falls only on a request that was left ungranted.
- The buffer never underflows and the timer never passes its limit.

Other behaviour is shown only by the bench scenarios:
- Words are written in order, carry correct data, and skip exactly the word lost to a timeout.
- Burst writes are contiguous.
- The timeout lands at the exact tick count, and ticks held low pause it.
- A new start discards stale words.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  // Sequencer states
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,  // waiting for a word or the end of the message
    SQ_ASK   = 2'd1,  // request raised, waiting for grant or timeout
    SQ_BURST = 2'd2,  // streaming the buffer after a burst grant
    SQ_DONE  = 2'd3   // message finished, waiting for the next start
  } sq_state_e;

  localparam logic [1:0] GBR_WIDTH = 2'd2;
endpackage

// File: rtl/rxd_fifo.sv
module rxd_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 32   // power of two
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign dout  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full && !clr) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else if (clr) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  // R2
  fifo_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |-> !empty);

  // R11
  fifo_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/rxd_hs_timer.sv
module rxd_hs_timer #(
  parameter int LIMIT = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expire = run && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (expire)  cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end

  // R5
  tmr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R5
  tmr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);
endmodule

// File: rtl/rxd_seq.sv
module rxd_seq
  import rxd_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          burst_en,
  input  logic          msg_start,
  input  logic          msg_end,
  input  logic          msg_ok,
  input  logic          mode_code,
  input  logic          fifo_empty,
  input  logic [W-1:0]  fifo_dout,
  input  logic          expire,
  input  logic          dma_gnt,
  output logic          fifo_pop,
  output logic          fifo_flush,
  output logic          dma_req,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [W-1:0]  wr_data,
  output logic          hs_fail_n,
  output logic          gbr_n
);
  sq_state_e     state;
  logic          burst_q, end_seen, ok_q, mc_q, fail_q;
  logic [AW-1:0] idx;
  logic [AW:0]   moved;
  logic [1:0]    gbr_cnt;

  logic ask, take, lapse, idle_drop, launch, finish, gbr_ok, streaming;

  assign ask       = (state == SQ_ASK);
  assign take      = ask && dma_gnt;
  assign lapse     = ask && !dma_gnt && expire;
  assign streaming = (state == SQ_BURST) && !fifo_empty;
  assign idle_drop = (state == SQ_IDLE) && burst_q && end_seen && !ok_q;
  assign launch    = (state == SQ_IDLE) && !fifo_empty && !idle_drop &&
                     (!burst_q || end_seen);
  assign finish    = (state == SQ_IDLE) && end_seen && fifo_empty && !idle_drop;
  assign gbr_ok    = ok_q && !mc_q && !fail_q && (moved != '0);

  assign fifo_pop   = take || (lapse && !burst_q) || streaming;
  assign fifo_flush = msg_start || (lapse && burst_q) || idle_drop;
  assign gbr_n      = (gbr_cnt == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      burst_q   <= 1'b0;
      end_seen  <= 1'b0;
      ok_q      <= 1'b0;
      mc_q      <= 1'b0;
      fail_q    <= 1'b0;
      idx       <= '0;
      moved     <= '0;
      gbr_cnt   <= 2'd0;
      dma_req   <= 1'b0;
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      hs_fail_n <= 1'b1;
    end else begin
      wr_stb <= 1'b0;
      if (gbr_cnt != 2'd0) gbr_cnt <= gbr_cnt - 1'b1;
      if (msg_start) begin
        state     <= SQ_IDLE;
        burst_q   <= burst_en;
        end_seen  <= 1'b0;
        ok_q      <= 1'b0;
        mc_q      <= 1'b0;
        fail_q    <= 1'b0;
        idx       <= '0;
        moved     <= '0;
        gbr_cnt   <= 2'd0;
        dma_req   <= 1'b0;
        hs_fail_n <= 1'b1;
      end else begin
        if (msg_end) begin
          end_seen <= 1'b1;
          ok_q     <= msg_ok;
          mc_q     <= mode_code;
        end
        case (state)
          SQ_IDLE: begin
            if (idle_drop) begin
              state <= SQ_DONE;
            end else if (launch) begin
              dma_req <= 1'b1;
              state   <= SQ_ASK;
            end else if (finish) begin
              state <= SQ_DONE;
              if (gbr_ok) gbr_cnt <= GBR_WIDTH;
            end
          end
          SQ_ASK: begin
            if (take) begin
              dma_req <= 1'b0;
              wr_stb  <= 1'b1;
              wr_data <= fifo_dout;
              wr_addr <= idx;
              idx     <= idx + 1'b1;
              moved   <= moved + 1'b1;
              state   <= burst_q ? SQ_BURST : SQ_IDLE;
            end else if (lapse) begin
              dma_req   <= 1'b0;
              fail_q    <= 1'b1;
              hs_fail_n <= 1'b0;
              if (!burst_q) idx <= idx + 1'b1;
              state <= SQ_IDLE;
            end
          end
          SQ_BURST: begin
            if (streaming) begin
              wr_stb  <= 1'b1;
              wr_data <= fifo_dout;
              wr_addr <= idx;
              idx     <= idx + 1'b1;
              moved   <= moved + 1'b1;
            end else begin
              state <= SQ_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_gnt) |=> !dma_req);

  // R2
  word_wr_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !burst_q) |-> $past(dma_gnt));

  // R3
  burst_req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && burst_q) |-> (end_seen && ok_q));

  // R8
  gbr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gbr_n) && !msg_start) |=> !gbr_n);

  // R8
  gbr_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gbr_n && $past(!gbr_n)) |=> gbr_n);

  // R9
  gbr_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gbr_n) |-> (ok_q && !mc_q && !fail_q));

  // R5
  hsf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_fail_n) |-> ($past(dma_req) && !$past(dma_gnt)));
endmodule

// File: rtl/rx_word_dma.sv
module rx_word_dma #(
  parameter int DATA_W    = 16,
  parameter int MAX_WORDS = 32,
  parameter int HS_LIMIT  = 2500
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          burst_en,
  input  logic                          msg_start,
  input  logic                          word_valid,
  input  logic [DATA_W-1:0]             word_data,
  input  logic                          msg_end,
  input  logic                          msg_ok,
  input  logic                          mode_code,
  input  logic                          tick,
  input  logic                          dma_gnt,
  output logic                          dma_req,
  output logic                          wr_stb,
  output logic [$clog2(MAX_WORDS)-1:0]  wr_addr,
  output logic [DATA_W-1:0]             wr_data,
  output logic                          hs_fail_n,
  output logic                          gbr_n
);
  localparam int ADDR_W = $clog2(MAX_WORDS);

  logic              f_pop, f_flush, f_empty, f_full, t_expire;
  logic [DATA_W-1:0] f_dout;

  rxd_fifo #(.W(DATA_W), .DEPTH(MAX_WORDS)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (f_flush),
    .push  (word_valid && !f_full),
    .din   (word_data),
    .pop   (f_pop),
    .dout  (f_dout),
    .empty (f_empty),
    .full  (f_full)
  );

  rxd_hs_timer #(.LIMIT(HS_LIMIT)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (dma_req),
    .tick   (tick),
    .expire (t_expire)
  );

  rxd_seq #(.W(DATA_W), .AW(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_en   (burst_en),
    .msg_start  (msg_start),
    .msg_end    (msg_end),
    .msg_ok     (msg_ok),
    .mode_code  (mode_code),
    .fifo_empty (f_empty),
    .fifo_dout  (f_dout),
    .expire     (t_expire),
    .dma_gnt    (dma_gnt),
    .fifo_pop   (f_pop),
    .fifo_flush (f_flush),
    .dma_req    (dma_req),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .hs_fail_n  (hs_fail_n),
    .gbr_n      (gbr_n)
  );
endmodule

// File: tb/test_rx_word_dma.sv
module test_rx_word_dma;
  localparam int DW  = 16;
  localparam int MW  = 32;
  localparam int LIM = 2500;
  localparam int AW  = 5;
  localparam int NONE = 99;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          burst_en = 1'b0, msg_start = 1'b0, word_valid = 1'b0;
  logic [DW-1:0] word_data = '0;
  logic          msg_end = 1'b0, msg_ok = 1'b0, mode_code = 1'b0, tick = 1'b1;
  logic          dma_gnt = 1'b0;
  logic          dma_req, wr_stb, hs_fail_n, gbr_n;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  rx_word_dma #(.DATA_W(DW), .MAX_WORDS(MW), .HS_LIMIT(LIM)) i_rx_word_dma (
    .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .msg_start(msg_start),
    .word_valid(word_valid), .word_data(word_data), .msg_end(msg_end),
    .msg_ok(msg_ok), .mode_code(mode_code), .tick(tick), .dma_gnt(dma_gnt),
    .dma_req(dma_req), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .hs_fail_n(hs_fail_n), .gbr_n(gbr_n)
  );

  // stimulus-side state
  int            total = 0, bad = 0;
  logic [DW-1:0] exp_data [MW];
  bit            is_burst = 1'b0, tick_gated = 1'b0;
  int            refuse_idx = NONE;

  // monitor-side state
  int mon_total = 0, mon_bad = 0;
  int wr_cnt = 0, stb_runs = 0, rises = 0, gbr_pulses = 0, gbr_run = 0;
  int last_addr = -1, req_hi = 0;
  bit end_flag = 1'b0, prev_req = 1'b0, prev_stb = 1'b0, prev_hsf = 1'b1;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mchk(bit ok, string tag, int act, int exp);
    mon_total++;
    if (!ok) begin
      mon_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // grant responder
  int  rq_idx = 0, gdly = 0;
  bit  gpend = 1'b0, rprev = 1'b0;
  always @(negedge clk) begin
    if (!rst_n || msg_start) begin
      rq_idx = 0; gpend = 1'b0; dma_gnt <= 1'b0;
    end else if (dma_gnt) begin
      dma_gnt <= 1'b0;
    end else begin
      if (dma_req && !rprev) begin
        gpend = (rq_idx != refuse_idx);
        gdly  = int'($urandom_range(0, 5));
        rq_idx++;
      end
      if (gpend) begin
        if (gdly == 0) begin dma_gnt <= 1'b1; gpend = 1'b0; end
        else gdly--;
      end
    end
    rprev = dma_req;
  end

  // output monitor
  always @(negedge clk) begin
    if (!rst_n || msg_start) begin
      wr_cnt = 0; stb_runs = 0; rises = 0; gbr_pulses = 0; gbr_run = 0;
      last_addr = -1; req_hi = 0; end_flag = 1'b0;
    end else begin
      if (msg_end) end_flag = 1'b1;
      if (wr_stb) begin
        wr_cnt++;
        if (!prev_stb) stb_runs++;
        mchk(wr_data == exp_data[wr_addr], is_burst ? "R3 data" : "R2 data",
             int'(wr_data), int'(exp_data[wr_addr]));
        mchk(int'(wr_addr) > last_addr, "R2 address order", int'(wr_addr), last_addr + 1);
        last_addr = int'(wr_addr);
      end
      if (dma_req && !prev_req) begin
        rises++;
        req_hi = 0;
        if (is_burst) mchk(end_flag, "R3 request before end", 0, 1);
      end
      if (dma_req) req_hi++;
      if (!hs_fail_n && prev_hsf && !tick_gated)
        mchk(req_hi == LIM, "R5 timeout latency", req_hi, LIM);
      if (!gbr_n) gbr_run++;
      else if (gbr_run != 0) begin
        gbr_pulses++;
        mchk(gbr_run == 2, "R8 pulse width", gbr_run, 2);
        gbr_run = 0;
      end
    end
    prev_req = dma_req; prev_stb = wr_stb; prev_hsf = hs_fail_n;
  end

  // expectation functions
  function automatic bit f_refused(bit b, int n, bit ok, int rf);
    return b ? (ok && rf == 0) : (rf < n);
  endfunction
  function automatic int f_writes(bit b, int n, bit ok, bit rfd);
    if (b) return (ok && !rfd) ? n : 0;
    return rfd ? n - 1 : n;
  endfunction
  function automatic int f_rises(bit b, int n, bit ok);
    return b ? (ok ? 1 : 0) : n;
  endfunction
  function automatic int f_gbr(bit ok, bit mc, bit rfd);
    return (ok && !mc && !rfd) ? 1 : 0;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic send(bit b, int n, bit ok, bit mc, int rf);
    is_burst = b;
    refuse_idx = rf;
    for (int i = 0; i < MW; i++) exp_data[i] = DW'($urandom);
    step();
    burst_en = b; msg_start = 1'b1;
    step();
    msg_start = 1'b0;
    chk(hs_fail_n == 1'b1, "R11 failure cleared by start", int'(hs_fail_n), 1);
    for (int i = 0; i < n; i++) begin
      word_valid = 1'b1; word_data = exp_data[i];
      step();
      word_valid = 1'b0;
      repeat ($urandom_range(0, 4)) step();
    end
    msg_end = 1'b1; msg_ok = ok; mode_code = mc;
    step();
    msg_end = 1'b0; msg_ok = 1'b0; mode_code = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 40) begin
      @(negedge clk);
      if (!dma_req && !wr_stb && gbr_n) q++;
      else q = 0;
    end
  endtask

  task automatic verify(bit b, int n, bit ok, bit mc, int rf);
    bit rfd = f_refused(b, n, ok, rf);
    int ew = f_writes(b, n, ok, rfd);
    int eg = f_gbr(ok, mc, rfd);
    chk(wr_cnt == ew, b ? (!ok ? "R10 writes" : (rfd ? "R7 writes" : "R3 writes"))
                        : (rfd ? "R6 writes" : "R2 writes"), wr_cnt, ew);
    chk(rises == f_rises(b, n, ok), b ? (ok ? "R3 requests" : "R10 requests") : "R2 requests",
        rises, f_rises(b, n, ok));
    chk(gbr_pulses == eg, eg != 0 ? "R8 good-block count" : "R9 good-block suppressed",
        gbr_pulses, eg);
    chk(hs_fail_n == !rfd, "R5 failure output", int'(hs_fail_n), int'(!rfd));
    if (b && ew > 0) chk(stb_runs == 1, "R3 contiguous burst", stb_runs, 1);
  endtask

  task automatic run_msg(bit b, int n, bit ok, bit mc, int rf);
    send(b, n, ok, mc, rf);
    wait_quiet();
    verify(b, n, ok, mc, rf);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(dma_req == 1'b0 && wr_stb == 1'b0, "R1 reset outputs low", int'(dma_req), 0);
    chk(hs_fail_n == 1'b1 && gbr_n == 1'b1, "R1 reset flags high", int'(gbr_n), 1);
    step(); rst_n = 1'b1;
    @(negedge clk);
    chk(dma_req == 1'b0 && wr_stb == 1'b0, "R1 after release", int'(wr_stb), 0);
    chk(hs_fail_n == 1'b1 && gbr_n == 1'b1, "R1 flags after release", int'(hs_fail_n), 1);

    void'($urandom(32'd7041));
    // directed corner cases
    run_msg(1'b0, 3, 1'b1, 1'b0, NONE);   // R2 R8
    run_msg(1'b1, 32, 1'b1, 1'b0, NONE);  // R3 R8 full buffer
    run_msg(1'b1, 4, 1'b0, 1'b0, NONE);   // R10
    run_msg(1'b0, 1, 1'b1, 1'b1, NONE);   // R9 mode code
    run_msg(1'b0, 3, 1'b0, 1'b0, NONE);   // R9 invalid, words still moved
    run_msg(1'b0, 4, 1'b1, 1'b0, 1);      // R6 R5
    run_msg(1'b1, 6, 1'b1, 1'b1, NONE);   // R9 burst mode code

    // R5 R4 R7: ticks held low pause the timeout
    tick = 1'b0; tick_gated = 1'b1;
    send(1'b1, 2, 1'b1, 1'b0, 0);
    repeat (3000) @(negedge clk);
    chk(hs_fail_n == 1'b1, "R5 no timeout without ticks", int'(hs_fail_n), 1);
    chk(dma_req == 1'b1, "R4 request held", int'(dma_req), 1);
    step(); tick = 1'b1;
    wait_quiet();
    verify(1'b1, 2, 1'b1, 1'b0, 0);
    tick_gated = 1'b0;

    // R11: stale words of an unfinished message are dropped
    is_burst = 1'b1; refuse_idx = NONE;
    step(); burst_en = 1'b1; msg_start = 1'b1;
    step(); msg_start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      word_valid = 1'b1; word_data = 16'hDEAD;
      step();
    end
    word_valid = 1'b0;
    run_msg(1'b1, 2, 1'b1, 1'b0, NONE);
    chk(wr_cnt == 2, "R11 only new words written", wr_cnt, 2);

    // constrained random
    for (int k = 0; k < 24; k++) begin
      bit b  = 1'($urandom_range(0, 1));
      int n  = int'($urandom_range(1, MW));
      bit ok = ($urandom_range(0, 99) < 85);
      bit mc = ($urandom_range(0, 99) < 10);
      int rf = ($urandom_range(0, 99) < 15) ? int'($urandom_range(0, b ? 0 : n - 1)) : NONE;
      run_msg(b, n, ok, mc, rf);
    end

    $display("test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total + mon_total + 1, bad + mon_bad + 1);
    $finish;
  end
endmodule